// File: doc/BRIEF.md
# Latched Serial-to-Parallel Shift Register

This block turns a serial bit stream into a parallel word. The word is held in a storage stage that has its own clock. A shift chain takes in one bit on every rising edge of a shift strobe. A separate storage strobe copies the whole chain into an output register. The parallel outputs therefore stay steady while a new word is being shifted in. The last chain stage is brought out as a serial cascade output, so several units wired one after another act as one longer register.

A typical use puts the block behind a serial peripheral bus master. The bus clock drives the shift strobe, the master's data line drives the serial input, and the chip select drives the storage strobe. The outputs then change once per burst, when chip select rises.

The whole block runs on one fast system clock. Both strobes and the serial input pass through a common synchronizer of configurable depth, and each strobe is detected by its rising edge. A low level on the chain reset clears the shift chain asynchronously. When the output enable is high, the outputs are forced to zero and a valid flag drops. This flag stands in for a high-impedance pad.

Top module: `sipo_latch_reg`

## Requirements
- R1: Each rising edge of `shift_clk` shifts the chain by one stage. `ser_in` enters stage 0, and stage i moves to stage i+1 (stage 0 is `par_out` bit 0 once stored). Holding `shift_clk` high, or keeping it low, causes no further shift.
- R2: The storage register takes a copy of the whole chain only on a rising edge of `store_clk`. Shifting alone leaves `par_out` unchanged.
- R3: While `mr_n` is low the shift chain reads all zero without waiting for a clock edge, and `ser_out` is 0. A store made after this captures zero.
- R4: Driving `mr_n` low leaves the storage register, and so `par_out`, unchanged.
- R5: While `oe_n` is high, `par_out` is all zero and `par_valid` is 0. While `oe_n` is low, `par_valid` is 1 and `par_out` shows the storage register.
- R6: `ser_out` equals the last chain stage, which is the bit shifted in WIDTH shifts earlier. After a byte is sent most significant bit first, `ser_out` equals that byte's bit 7.
- R7: When `shift_clk` and `store_clk` rise in the same cycle, the storage register captures the chain value from before that cycle's shift.
- R8: Two units are chained by feeding the near unit's `ser_out` into the far unit's `ser_in`, with shared strobes. After 16 shifts and a store, the far unit holds the first byte sent and the near unit holds the second, each byte sent most significant bit first.
- R9: While `rst_n` is low, the chain, the storage register and the edge detectors are cleared, so `par_out` and `ser_out` read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all strobes |
| rst_n | input | 1 | Active-low system reset for all state |
| ser_in | input | 1 | Serial data into chain stage 0 |
| shift_clk | input | 1 | Shift strobe, acts on its rising edge |
| store_clk | input | 1 | Storage strobe, acts on its rising edge |
| mr_n | input | 1 | Active-low asynchronous clear of the shift chain |
| oe_n | input | 1 | Active-low output enable |
| par_out | output | WIDTH | Parallel outputs from the storage register |
| par_valid | output | 1 | High while the parallel outputs are enabled |
| ser_out | output | 1 | Cascade output from the last chain stage |

## Verification
The hardest case to reach from the ports is the shift strobe and the storage strobe rising in the very same system cycle. If they arrive only one cycle apart, the ordering question is never tested. The bench therefore raises both strobes in a single assignment, so they pass through the shared synchronizer together. It then stores a second time to show that the shifted value is also present. Chain order is checked by wiring a second unit behind the first and sending two different bytes.

// File: rtl/sipo_pkg.sv
package sipo_pkg;
   localparam int SIPO_MAX_SYNC = 4;
   localparam int SIPO_N_LINES  = 3;
   typedef enum int {
      LINE_DATA  = 0,
      LINE_SHIFT = 1,
      LINE_STORE = 2
   } sipo_line_e;
endpackage

// File: rtl/sipo_sync.sv
module sipo_sync #(
   parameter int WIDTH  = 3,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_in,
   output logic [WIDTH-1:0] d_out
);
   if (STAGES == 0) begin : g_direct
      assign d_out = d_in;
   end else begin : g_flops
      logic [WIDTH-1:0] stg [STAGES];
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= '0;
         end else begin
            stg[0] <= d_in;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
         end
      end
      assign d_out = stg[STAGES-1];
   end
endmodule

// File: rtl/sipo_rise.sv
module sipo_rise #(
   parameter int WIDTH = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] level,
   output logic [WIDTH-1:0] rise
);
   logic [WIDTH-1:0] prev_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= '0;
      else        prev_q <= level;
   end
   for (genvar g = 0; g < WIDTH; g++) begin : g_bit
      assign rise[g] = level[g] & ~prev_q[g];
   end
endmodule

// File: rtl/sipo_shift_chain.sv
module sipo_shift_chain #(
   parameter int WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             mr_n,
   input  logic             shift_en,
   input  logic             din,
   output logic [WIDTH-1:0] chain_q,
   output logic             last_bit
);
   logic clr_n;
   assign clr_n = rst_n & mr_n;
   always_ff @(posedge clk or negedge clr_n) begin
      if (!clr_n)        chain_q <= '0;
      else if (shift_en) chain_q <= {chain_q[WIDTH-2:0], din};
   end
   assign last_bit = chain_q[WIDTH-1];
endmodule

// File: rtl/sipo_store.sv
module sipo_store #(
   parameter int WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic             oe_n,
   input  logic [WIDTH-1:0] chain_q,
   output logic [WIDTH-1:0] store_q,
   output logic [WIDTH-1:0] par_out,
   output logic             par_valid
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    store_q <= '0;
      else if (load) store_q <= chain_q;
   end
   assign par_valid = ~oe_n;
   assign par_out   = store_q & {WIDTH{par_valid}};
endmodule

// File: rtl/sipo_latch_reg.sv
module sipo_latch_reg
   import sipo_pkg::*;
#(
   parameter int WIDTH       = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ser_in,
   input  logic             shift_clk,
   input  logic             store_clk,
   input  logic             mr_n,
   input  logic             oe_n,
   output logic [WIDTH-1:0] par_out,
   output logic             par_valid,
   output logic             ser_out
);
   if (WIDTH < 2) begin : g_bad_width
      $fatal(1, "WIDTH must be at least 2");
   end
   if (SYNC_STAGES < 0 || SYNC_STAGES > SIPO_MAX_SYNC) begin : g_bad_sync
      $fatal(1, "SYNC_STAGES out of range");
   end

   logic [SIPO_N_LINES-1:0] raw_lines, sync_lines;
   logic [1:0]              strobe_rise;
   logic                    shift_rise, store_rise;
   logic [WIDTH-1:0]        chain_q, store_q;

   assign raw_lines[LINE_DATA]  = ser_in;
   assign raw_lines[LINE_SHIFT] = shift_clk;
   assign raw_lines[LINE_STORE] = store_clk;

   sipo_sync #(.WIDTH(SIPO_N_LINES), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d_in(raw_lines), .d_out(sync_lines));

   sipo_rise #(.WIDTH(2)) u_rise (
      .clk(clk), .rst_n(rst_n),
      .level({sync_lines[LINE_STORE], sync_lines[LINE_SHIFT]}),
      .rise(strobe_rise));

   assign shift_rise = strobe_rise[0];
   assign store_rise = strobe_rise[1];

   sipo_shift_chain #(.WIDTH(WIDTH)) u_chain (
      .clk(clk), .rst_n(rst_n), .mr_n(mr_n), .shift_en(shift_rise),
      .din(sync_lines[LINE_DATA]), .chain_q(chain_q), .last_bit(ser_out));

   sipo_store #(.WIDTH(WIDTH)) u_store (
      .clk(clk), .rst_n(rst_n), .load(store_rise), .oe_n(oe_n),
      .chain_q(chain_q), .store_q(store_q), .par_out(par_out),
      .par_valid(par_valid));
endmodule

// File: rtl/sipo_latch_reg_chk.sv
module sipo_latch_reg_chk #(
   parameter int WIDTH = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             mr_n,
   input logic             oe_n,
   input logic             shift_rise,
   input logic             store_rise,
   input logic [WIDTH-1:0] chain_q,
   input logic [WIDTH-1:0] store_q,
   input logic [WIDTH-1:0] par_out,
   input logic             par_valid
);
   AST_SHIFT_MOVES: assert property (@(posedge clk) disable iff (!rst_n)
      (shift_rise && mr_n) |=> (!mr_n || chain_q[WIDTH-1:1] == $past(chain_q[WIDTH-2:0]))); // R1
   AST_NO_SPURIOUS_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
      (!shift_rise && mr_n) |=> (!mr_n || $stable(chain_q))); // R1
   AST_SINGLE_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      shift_rise |=> !shift_rise); // R1
   AST_STORE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      !store_rise |=> $stable(store_q)); // R2
   AST_STORE_PRE_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
      store_rise |=> store_q == $past(chain_q)); // R7
   AST_MR_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      !mr_n |-> chain_q == '0); // R3
   AST_MR_KEEPS_STORE: assert property (@(posedge clk) disable iff (!rst_n)
      (!mr_n && !store_rise) |=> $stable(store_q)); // R4
   AST_OE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      oe_n |-> (par_out == '0 && !par_valid)); // R5
   AST_OE_ON: assert property (@(posedge clk) disable iff (!rst_n)
      !oe_n |-> (par_valid && par_out == store_q)); // R5
endmodule

bind sipo_latch_reg sipo_latch_reg_chk #(.WIDTH(WIDTH)) u_chk (
   .clk(clk), .rst_n(rst_n), .mr_n(mr_n), .oe_n(oe_n),
   .shift_rise(shift_rise), .store_rise(store_rise),
   .chain_q(chain_q), .store_q(store_q),
   .par_out(par_out), .par_valid(par_valid));

// File: tb/sipo_latch_reg_bench.sv
module sipo_latch_reg_bench;
   localparam int CLK_PERIOD = 10;
   localparam int W = 8;

   logic clk = 0, rst_n = 0, ser_in = 0, shift_clk = 0, store_clk = 0;
   logic mr_n = 1, oe_n = 0;
   logic [W-1:0] par_out, far_par;
   logic par_valid, ser_out, far_valid, far_ser;

   int checks = 0, fails = 0;
   bit done = 0;

   logic [W-1:0] m_near_ch = 0, m_near_st = 0, m_far_ch = 0, m_far_st = 0;

   logic [W-1:0] q_par[$];
   logic [W-1:0] q_far[$];
   logic         q_val[$];
   logic         q_so[$];
   string        q_tag[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   sipo_latch_reg #(.WIDTH(W)) u_sipo_latch_reg (
      .clk(clk), .rst_n(rst_n), .ser_in(ser_in), .shift_clk(shift_clk),
      .store_clk(store_clk), .mr_n(mr_n), .oe_n(oe_n),
      .par_out(par_out), .par_valid(par_valid), .ser_out(ser_out));

   sipo_latch_reg #(.WIDTH(W)) u_far (
      .clk(clk), .rst_n(rst_n), .ser_in(ser_out), .shift_clk(shift_clk),
      .store_clk(store_clk), .mr_n(mr_n), .oe_n(oe_n),
      .par_out(far_par), .par_valid(far_valid), .ser_out(far_ser));

   task automatic check(input bit ok, input string tag, input string msg);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: %s", tag, msg);
      end
   endtask

   // monitor: pops expected items and compares against live outputs
   initial begin
      forever begin
         @(negedge clk);
         if (q_tag.size() > 0) begin
            logic [W-1:0] ep, ef;
            logic ev, es;
            string t;
            ep = q_par.pop_front(); ef = q_far.pop_front();
            ev = q_val.pop_front(); es = q_so.pop_front(); t = q_tag.pop_front();
            check(par_out == ep, t, $sformatf("par_out actual %h expected %h", par_out, ep));
            check(par_valid == ev, t, $sformatf("par_valid actual %b expected %b", par_valid, ev));
            check(ser_out == es, t, $sformatf("ser_out actual %b expected %b", ser_out, es));
            check(far_par == ef, t, $sformatf("far par_out actual %h expected %h", far_par, ef));
         end
      end
   end

   task automatic wait_clk(input int n);
      repeat (n) @(posedge clk);
      #2;
   endtask

   task automatic expect_model(input string tag);
      q_par.push_back(oe_n ? '0 : m_near_st);
      q_far.push_back(oe_n ? '0 : m_far_st);
      q_val.push_back(!oe_n);
      q_so.push_back(m_near_ch[W-1]);
      q_tag.push_back(tag);
      while (q_tag.size() > 0) @(posedge clk);
      #2;
   endtask

   task automatic do_shift(input logic b);
      ser_in = b;
      wait_clk(3);
      shift_clk = 1;
      m_far_ch  = {m_far_ch[W-2:0], m_near_ch[W-1]};
      m_near_ch = {m_near_ch[W-2:0], b};
      wait_clk(4);
      shift_clk = 0;
      wait_clk(3);
   endtask

   task automatic do_store();
      store_clk = 1;
      m_near_st = m_near_ch;
      m_far_st  = m_far_ch;
      wait_clk(5);
      store_clk = 0;
      wait_clk(3);
   endtask

   task automatic send_byte(input logic [W-1:0] v);
      for (int i = W-1; i >= 0; i--) do_shift(v[i]);
   endtask

   initial begin
      wait_clk(4);
      rst_n = 1;
      wait_clk(2);
      expect_model("R9 reset state");

      send_byte(8'hA5);
      expect_model("R2 no store yet");
      check(ser_out == 1'b1, "R6", $sformatf("ser_out actual %b expected 1", ser_out));
      do_store();
      expect_model("R2 stored first byte");
      check(par_out == 8'hA5, "R2", $sformatf("par_out actual %h expected a5", par_out));

      send_byte(8'h3C);
      do_store();
      expect_model("R8 chained bytes");
      check(far_par == 8'hA5 && par_out == 8'h3C, "R8",
            $sformatf("far/near actual %h/%h expected a5/3c", far_par, par_out));

      oe_n = 1;
      wait_clk(1);
      expect_model("R5 disabled");
      oe_n = 0;
      wait_clk(1);
      expect_model("R5 enabled");

      // strobe held high: exactly one shift
      ser_in = 1;
      wait_clk(3);
      shift_clk = 1;
      m_far_ch  = {m_far_ch[W-2:0], m_near_ch[W-1]};
      m_near_ch = {m_near_ch[W-2:0], 1'b1};
      wait_clk(30);
      do_store();
      expect_model("R1 held strobe single shift");
      check(par_out == 8'h79, "R1", $sformatf("par_out actual %h expected 79", par_out));
      shift_clk = 0;
      wait_clk(20);
      do_store();
      expect_model("R1 low strobe no shift");

      // chain clear leaves storage alone
      mr_n = 0;
      m_near_ch = '0; m_far_ch = '0;
      wait_clk(2);
      expect_model("R3 chain cleared");
      expect_model("R4 storage kept");
      check(par_out == 8'h79, "R4", $sformatf("par_out actual %h expected 79", par_out));
      mr_n = 1;
      wait_clk(2);
      do_store();
      expect_model("R3 store after clear");

      // simultaneous strobes
      send_byte(8'h96);
      ser_in = 0;
      wait_clk(3);
      shift_clk = 1; store_clk = 1;
      m_near_st = m_near_ch; m_far_st = m_far_ch;
      m_far_ch  = {m_far_ch[W-2:0], m_near_ch[W-1]};
      m_near_ch = {m_near_ch[W-2:0], 1'b0};
      wait_clk(5);
      shift_clk = 0; store_clk = 0;
      wait_clk(3);
      expect_model("R7 pre-shift capture");
      check(par_out == 8'h96, "R7", $sformatf("par_out actual %h expected 96", par_out));
      do_store();
      expect_model("R7 shifted value");
      check(par_out == 8'h2C, "R7", $sformatf("par_out actual %h expected 2c", par_out));

      // system reset mid-run
      rst_n = 0;
      m_near_ch = '0; m_far_ch = '0; m_near_st = '0; m_far_st = '0;
      wait_clk(2);
      check(par_out == '0 && ser_out == 1'b0, "R9",
            $sformatf("par/ser actual %h/%b expected 00/0", par_out, ser_out));
      rst_n = 1;
      wait_clk(2);
      expect_model("R9 after reset");

      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 200000);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end
endmodule